// File: doc/BRIEF.md
# Addressing-Mode Operand Fetch Unit

This block resolves the operand of a load-to-accumulator instruction. An instruction is presented for one cycle on `start` as a 4-bit mode, a register-select field and an address/operand field. The block computes the effective address under the chosen rule and reads a synchronous memory when the mode needs it. It then loads the resulting operand into its accumulator and pulses `done`. A pointer-through-memory mode makes two reads in sequence. The post-increment and pre-decrement register modes write the updated pointer back to the register file.

The register file, the program counter, the index register and the base register all sit outside the block. The register file is read combinationally through `rf_sel`/`rf_rdata` and written through `rf_we`/`rf_wdata`. The program counter arrives already advanced past the instruction. All address arithmetic wraps modulo 2^AW (AW = 12 by default). The data width DW defaults to 16 and the register-select width RK to 2, which gives four registers.

Top module: `opfetch_unit`

## Requirements
- R1: After reset the accumulator is 0 and `done`, `illegal`, `busy`, `mem_re` and `rf_we` are low.
- R2: Mode 0 (implied) complements the accumulator. `done` is high in the issue cycle and no memory read is made.
- R3: Mode 1 (immediate) loads the address field, zero-extended to DW, into the accumulator. `done` is high in the issue cycle and no memory read is made.
- R4: Mode 2 (register) loads register `rsel`, one of 2^RK registers, into the accumulator. `done` is high in the issue cycle.
- R5: Mode 3 (register indirect) reads memory at the low AW bits of register `rsel` and loads that word.
- R6: Mode 4 (post-increment) reads memory at the low AW bits of R, where R is register `rsel`. In the issue cycle it writes R+1 (modulo 2^DW) back to register `rsel`.
- R7: Mode 5 (pre-decrement) reads memory at the low AW bits of R-1. In the issue cycle it writes R-1 (modulo 2^DW) back to register `rsel`.
- R8: Mode 6 (direct) reads memory at the field. Mode 7 (indirect) first reads memory at the field, then reads memory at the low AW bits of the word returned, and loads the second word.
- R9: Effective addresses are formed modulo 2^AW. Mode 8 uses pc + field, mode 9 uses field + index register, and mode 10 uses field + base register.
- R10: Each read has one cycle of latency. `done` is high in the cycle in which the last read data returns, which is one cycle after issue for single-read modes and two cycles after issue for mode 7. The accumulator shows the new value after the clock edge that ends a `done` cycle.
- R11: Modes 11 to 15 pulse `illegal` in the issue cycle. They raise no `done`, make no read and no register write, and leave the accumulator unchanged.
- R12: While `busy` is high, `start` is ignored. Outside an instruction, `mem_re`, `done` and `rf_we` stay low.
- R13: The accumulator changes only at the clock edge that ends a cycle with `done` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Issue an instruction (taken when not busy) |
| mode | input | 4 | Addressing mode, 0 to 10 legal |
| rsel | input | RK | Register-select field |
| field | input | AW | Address or operand field |
| pc | input | AW | Program counter, already advanced |
| xr | input | AW | Index register |
| br | input | AW | Base register |
| rf_sel | output | RK | Register file read/write select |
| rf_rdata | input | DW | Selected register content |
| rf_we | output | 1 | Register write-back enable |
| rf_wdata | output | DW | Updated register value |
| mem_re | output | 1 | Memory read request |
| mem_addr | output | AW | Memory read address |
| mem_rdata | input | DW | Read data, valid one cycle after the request |
| acc | output | DW | Accumulator |
| done | output | 1 | Accumulator loads at the end of this cycle |
| illegal | output | 1 | Unused mode value presented |
| busy | output | 1 | A memory-mode instruction is in flight |

## Verification
The assertions watch several rules on every cycle. They check that the accumulator never moves outside a `done` cycle, that an illegal mode produces no done, read or write, and that register write-back only happens when a post-increment or pre-decrement instruction issues. They also check the one-cycle and two-cycle completion timing of the memory modes and the silence of the memory port while idle. The bench scenarios show the values: each mode's effective address and operand, wrap-around of the relative, base and register-derived addresses, the pointer values written back, and a second `start` held high during a busy cycle having no effect.

// File: rtl/opfetch_unit.sv
module opfetch_unit #(
  parameter int AW = 12,
  parameter int DW = 16,
  parameter int RK = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [3:0]    mode,
  input  logic [RK-1:0] rsel,
  input  logic [AW-1:0] field,
  input  logic [AW-1:0] pc,
  input  logic [AW-1:0] xr,
  input  logic [AW-1:0] br,
  output logic [RK-1:0] rf_sel,
  input  logic [DW-1:0] rf_rdata,
  output logic          rf_we,
  output logic [DW-1:0] rf_wdata,
  output logic          mem_re,
  output logic [AW-1:0] mem_addr,
  input  logic [DW-1:0] mem_rdata,
  output logic [DW-1:0] acc,
  output logic          done,
  output logic          illegal,
  output logic          busy
);
  typedef enum logic [1:0] {S_IDLE, S_PTR, S_DATA} st_t;
  st_t st;

  logic          issue, legal, memmode, automode;
  logic [AW-1:0] ea;
  logic [DW-1:0] rf_dec;

  assign issue    = start && st == S_IDLE;
  assign legal    = mode <= 4'd10;
  assign memmode  = legal && mode >= 4'd3;
  assign automode = mode == 4'd4 || mode == 4'd5;
  assign rf_dec   = rf_rdata - 1'b1;
  assign rf_sel   = rsel;

  always_comb begin
    case (mode)
      4'd3, 4'd4: ea = rf_rdata[AW-1:0];
      4'd5:       ea = rf_dec[AW-1:0];
      4'd8:       ea = pc + field;
      4'd9:       ea = field + xr;
      4'd10:      ea = field + br;
      default:    ea = field;
    endcase
  end

  assign mem_re   = (issue && memmode) || st == S_PTR;
  assign mem_addr = (st == S_PTR) ? mem_rdata[AW-1:0] : ea;
  assign rf_we    = issue && automode;
  assign rf_wdata = (mode == 4'd4) ? rf_rdata + 1'b1 : rf_dec;
  assign done     = (issue && legal && !memmode) || st == S_DATA;
  assign illegal  = issue && !legal;
  assign busy     = st != S_IDLE;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st  <= S_IDLE;
      acc <= '0;
    end else begin
      case (st)
        S_IDLE: if (issue && memmode) st <= (mode == 4'd7) ? S_PTR : S_DATA;
        S_PTR:  st <= S_DATA;
        default: st <= S_IDLE;
      endcase
      if (st == S_DATA) acc <= mem_rdata;
      else if (issue) begin
        case (mode)
          4'd0: acc <= ~acc;
          4'd1: acc <= DW'(field);
          4'd2: acc <= rf_rdata;
          default: ;
        endcase
      end
    end
  end
endmodule

module opfetch_unit_chk #(
  parameter int DW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic [3:0]    mode,
  input logic          busy,
  input logic          done,
  input logic          illegal,
  input logic          mem_re,
  input logic          rf_we,
  input logic [DW-1:0] acc
);
  assert_acc_only_on_done_R13: assert property (@(posedge clk) disable iff (!rst_n)
    !done |=> $stable(acc));
  assert_illegal_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |-> (!done && !mem_re && !rf_we));
  assert_idle_silent_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |-> (!mem_re && !done && !rf_we));
  assert_writeback_auto_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rf_we |-> (start && !busy && (mode == 4'd4 || mode == 4'd5)));
  assert_indirect_second_read_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && mode == 4'd7) |=> (mem_re && !done && busy));
  assert_single_read_latency_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && mode >= 4'd3 && mode <= 4'd10 && mode != 4'd7) |=> (done && !mem_re));
endmodule

bind opfetch_unit opfetch_unit_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .busy(busy),
  .done(done), .illegal(illegal), .mem_re(mem_re), .rf_we(rf_we), .acc(acc)
);

// File: tb/test_opfetch_unit.sv
`timescale 1ns/1ps
module test_opfetch_unit;
  localparam int AW = 12;
  localparam int DW = 16;
  localparam int RK = 2;
  localparam int NV = 17;

  logic          clk = 0, rst_n = 0, start = 0;
  logic [3:0]    mode = 0;
  logic [RK-1:0] rsel = 0;
  logic [AW-1:0] field = 0, pc = 0;
  logic [AW-1:0] xr = 12'h100, br = 12'hF80;
  logic [RK-1:0] rf_sel;
  logic [DW-1:0] rf_rdata, rf_wdata, mem_rdata, acc;
  logic          rf_we, mem_re, done, illegal, busy;
  logic [AW-1:0] mem_addr;

  logic [DW-1:0] rf [4];
  logic [DW-1:0] rf_m [4];
  logic [DW-1:0] acc_m = '0;
  int n_chk = 0, n_bad = 0;

  always #10 clk = ~clk;

  opfetch_unit #(.AW(AW), .DW(DW), .RK(RK)) i_opfetch_unit (
    .clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .rsel(rsel),
    .field(field), .pc(pc), .xr(xr), .br(br), .rf_sel(rf_sel),
    .rf_rdata(rf_rdata), .rf_we(rf_we), .rf_wdata(rf_wdata),
    .mem_re(mem_re), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
    .acc(acc), .done(done), .illegal(illegal), .busy(busy));

  function automatic logic [DW-1:0] memf(input logic [AW-1:0] a);
    return {4'h5, a ^ 12'h3C3};
  endfunction

  assign rf_rdata = rf[rf_sel];
  always @(posedge clk) begin
    if (rf_we) rf[rf_sel] <= rf_wdata;
    if (mem_re) mem_rdata <= memf(mem_addr);
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // {mode, rsel, field, pc}
  localparam logic [29:0] VEC [NV] = '{
    {4'd1,  2'd0, 12'hABC, 12'h000},  // R3
    {4'd1,  2'd0, 12'hFFF, 12'h000},  // R3 zero extend
    {4'd0,  2'd0, 12'h000, 12'h000},  // R2
    {4'd2,  2'd3, 12'h000, 12'h000},  // R4
    {4'd0,  2'd0, 12'h000, 12'h000},  // R2
    {4'd3,  2'd0, 12'h000, 12'h000},  // R5
    {4'd4,  2'd1, 12'h000, 12'h000},  // R6 0FFF -> 1000
    {4'd4,  2'd1, 12'h000, 12'h000},  // R6 low bits wrap
    {4'd5,  2'd2, 12'h000, 12'h000},  // R7 0 -> FFFF
    {4'd6,  2'd0, 12'h123, 12'h000},  // R8
    {4'd7,  2'd0, 12'h200, 12'h000},  // R8 indirect
    {4'd8,  2'd0, 12'h032, 12'h1F5},  // R9 501+50
    {4'd8,  2'd0, 12'h020, 12'hFF0},  // R9 wrap
    {4'd9,  2'd0, 12'h0F0, 12'h000},  // R9 index
    {4'd10, 2'd0, 12'h0A0, 12'h000},  // R9 base wrap
    {4'd12, 2'd1, 12'h111, 12'h000},  // R11
    {4'd15, 2'd0, 12'h222, 12'h000}   // R11
  };

  task automatic exec(input logic [3:0] m, input logic [1:0] r, input logic [AW-1:0] f, input logic [AW-1:0] p);
    logic [AW-1:0] ea, ptr;
    logic [DW-1:0] op, nreg, rv;
    int lat;
    bit leg, wr;
    string tg;
    leg = (m <= 4'd10); wr = (m == 4'd4 || m == 4'd5);
    rv = rf_m[r]; lat = 1; op = acc_m; nreg = rv; ea = f; ptr = '0;
    tg = $sformatf("R%0d", (m == 0) ? 2 : (m == 1) ? 3 : (m == 2) ? 4 : (m == 3) ? 5 :
                   (m == 4) ? 6 : (m == 5) ? 7 : (m <= 7) ? 8 : (m <= 10) ? 9 : 11);
    case (m)
      4'd0: begin op = ~acc_m; lat = 0; end
      4'd1: begin op = DW'(f); lat = 0; end
      4'd2: begin op = rv; lat = 0; end
      4'd3: ea = rv[AW-1:0];
      4'd4: begin ea = rv[AW-1:0]; nreg = rv + 1'b1; end
      4'd5: begin nreg = rv - 1'b1; ea = nreg[AW-1:0]; end
      4'd6: ea = f;
      4'd7: begin ptr = memf(f)[AW-1:0]; ea = ptr; lat = 2; end
      4'd8: ea = p + f;
      4'd9: ea = f + xr;
      4'd10: ea = f + br;
      default: lat = 0;
    endcase
    if (leg && lat > 0) op = memf(ea);
    @(negedge clk);
    start = 1; mode = m; rsel = r; field = f; pc = p;
    #1;
    chk(done == (leg && lat == 0), {tg, " done at issue"}, done, leg && lat == 0);
    chk(illegal == !leg, "R11 illegal flag", illegal, !leg);
    chk(mem_re == (leg && lat > 0), {tg, " read at issue"}, mem_re, leg && lat > 0);
    if (leg && lat > 0)
      chk(mem_addr == ((m == 4'd7) ? f : ea), {tg, " first address"}, mem_addr, (m == 4'd7) ? f : ea);
    chk(rf_we == wr, {tg, " write enable"}, rf_we, wr);
    if (wr) chk(rf_wdata == nreg, {tg, " write data"}, rf_wdata, nreg);
    @(negedge clk); start = 0; #1;
    if (leg) begin
      for (int k = 1; k <= lat; k++) begin
        if (m == 4'd7 && k == 1)
          chk(mem_re && mem_addr == ptr, "R8 second read address", mem_addr, ptr);
        chk(done == (k == lat), "R10 done timing", done, k == lat);
        @(negedge clk); #1;
      end
    end
    if (leg) acc_m = op;
    if (wr) rf_m[r] = nreg;
    chk(acc == acc_m, {tg, " accumulator"}, acc, acc_m);
    chk(!busy && !done, "R12 idle after", {busy, done}, 0);
    for (int i = 0; i < 4; i++)
      chk(rf[i] == rf_m[i], {tg, " register file"}, rf[i], rf_m[i]);
  endtask

  initial begin
    #(20 * 200000);
    n_bad++; n_chk++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    rf[0] = 16'h0040; rf[1] = 16'h0FFF; rf[2] = 16'h0000; rf[3] = 16'h8A5C;
    for (int i = 0; i < 4; i++) rf_m[i] = rf[i];
    repeat (3) @(negedge clk);
    #1;
    chk(acc == 0 && !done && !illegal && !busy && !mem_re && !rf_we, "R1 reset state",
        {acc, done, illegal, busy, mem_re, rf_we}, 0);
    @(negedge clk); rst_n = 1;
    for (int v = 0; v < NV; v++)
      exec(VEC[v][29:26], VEC[v][25:24], VEC[v][23:12], VEC[v][11:0]);

    // R12: start held high during the busy cycle is ignored
    @(negedge clk);
    start = 1; mode = 4'd6; field = 12'h300;
    @(negedge clk);
    mode = 4'd0; #1;
    chk(done && busy && !rf_we && !mem_re, "R12 busy start ignored", {done, busy, rf_we, mem_re}, 4'b1100);
    @(negedge clk); start = 0; #1;
    acc_m = memf(12'h300);
    chk(acc == acc_m, "R12 accumulator not complemented", acc, acc_m);
    chk(!busy, "R12 idle", busy, 0);

    // R13: accumulator stays put across idle cycles
    repeat (3) @(negedge clk);
    #1;
    chk(acc == acc_m, "R13 accumulator held", acc, acc_m);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule